// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block lets software manage 10G-class PHYs over the two-wire MDC/MDIO bus using Clause 45 framing. It exposes four 32-bit registers on a simple write strobe and a combinational read port. Software first programs a clock divider and a target (PHY port and MMD device address). It then starts a frame as a side effect of an ordinary register write. Writing the address register sends an address frame. Writing the data register sends a write frame. Writing the control register with its read flag set sends a read frame.

MDC is derived from the system clock. Every frame is 64 bits long, sent most significant bit first. On a read, the master releases MDIO from the turnaround onward. It checks that the PHY pulls the line low in the second turnaround bit, and it shifts in 16 data bits. While a frame is in flight, busy is visible in both the status register and the data register, and register writes are dropped.

Register map (word index on `bus_addr`):
- 0 status/config: [0] busy, [1] read error, [15:8] MDC divider (writable, reset 100).
- 1 control: [4:0] MMD device address, [12:8] port address, [15] start read (write-only, reads 0).
- 2 address: [15:0] register number.
- 3 data: [15:0] write value or read result, [31] frame-in-progress flag for write and read frames.

Top module: `mdio45_master`

## Requirements
- R1: After reset, MDC is low, MDIO is not driven, status reads busy 0, error 0 and divider 100, and the control, address and data registers read 0.
- R2: While a frame runs, MDC has period 2×(divider+1) clocks and starts low. MDC stays low whenever no frame is active.
- R3: A write to register 2 stores bits [15:0] and sends a frame: 32 ones, start 00, opcode 00, 5-bit port, 5-bit device, turnaround 10, then the 16-bit register number.
- R4: A write to register 3 stores bits [15:0] and sends the same layout with opcode 01 and the value as payload. Bit 31 of register 3 reads 1 from the cycle after the write until the frame ends.
- R5: A write to register 1 with bit 15 set loads port and device and sends a read frame with opcode 11. MDIO output enable is low from the first turnaround bit to the end of the frame, and bit 31 of register 3 reads 1 meanwhile.
- R6: After a read frame, register 3 bits [15:0] hold the 16 bits sampled on MDIO at MDC rising edges, first bit most significant.
- R7: If MDIO is high at the MDC rising edge of the second turnaround bit of a read, status bit 1 becomes 1. It returns to 0 when the next read frame starts.
- R8: Any register write accepted in a cycle where busy is 1 is discarded. This includes the cycle in which the last bit finishes, and the write starts no frame.
- R9: The driven MDIO level changes only together with a falling MDC edge. Busy drops together with the final falling MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO level seen on the pin |

## Verification
A register write and frame completion can land on the same clock edge: the final falling MDC edge clears busy while a new write is strobed. The bench counts down the model's frame clock until it sits one cycle before completion, then writes the address register. It then writes again one cycle later. The per-cycle model expects the first write to leave the address register and the bus untouched, and the second write to start a fresh frame. A read with no PHY response, followed by a good read, checks that the error flag rises mid-frame and clears at the next read start.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;
  localparam int FRAME_W  = 64;
  localparam int DATA_W   = 16;
  localparam int PHYAD_W  = 5;
  localparam int PRE_W    = 32;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b11
  } mdio_op_e;

  localparam logic [1:0] REG_STAT = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_ADDR = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int CTRL_RD_BIT = 15;
endpackage

// File: rtl/mdio45_clkgen.sv
module mdio45_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             wrap;

  assign wrap      = run && (cnt_q == div);
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = '0;
    mdc_d = 1'b0;
    if (run) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
      mdc_d = wrap ? ~mdc_q : mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R2: the clock is parked low whenever no frame runs
  p_mdc_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mdc_q);
endmodule

// File: rtl/mdio45_shifter.sv
module mdio45_shifter
  import mdio45_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_read,
  input  logic [FRAME_W-1:0] frame,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               mdio_i,
  output logic               active,
  output logic               done,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [DATA_W-1:0]  rdata,
  output logic               rd_err
);
  localparam int BIT_W  = $clog2(FRAME_W);
  localparam int TA_POS = FRAME_W - DATA_W - 2;
  localparam logic [BIT_W-1:0] TA_FIRST = BIT_W'(TA_POS);
  localparam logic [BIT_W-1:0] TA_LAST  = BIT_W'(TA_POS + 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  logic               active_q, active_d;
  logic               read_q, read_d;
  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic [BIT_W-1:0]   bitn_q, bitn_d;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               err_q, err_d;

  assign done    = active_q && fall_tick && (bitn_q == BIT_LAST);
  assign active  = active_q;
  assign mdio_o  = active_q ? sreg_q[FRAME_W-1] : 1'b1;
  assign mdio_oe = active_q && !(read_q && (bitn_q >= TA_FIRST));
  assign rdata   = rdata_q;
  assign rd_err  = err_q;

  always_comb begin
    active_d = active_q;
    read_d   = read_q;
    sreg_d   = sreg_q;
    bitn_d   = bitn_q;
    rdata_d  = rdata_q;
    err_d    = err_q;
    if (start) begin
      active_d = 1'b1;
      read_d   = start_read;
      sreg_d   = frame;
      bitn_d   = '0;
      if (start_read) err_d = 1'b0;
    end else if (active_q) begin
      if (fall_tick) begin
        if (bitn_q == BIT_LAST) begin
          active_d = 1'b0;
        end else begin
          sreg_d = {sreg_q[FRAME_W-2:0], 1'b1};
          bitn_d = bitn_q + 1'b1;
        end
      end
      if (rise_tick && read_q) begin
        if (bitn_q == TA_LAST) err_d = mdio_i;
        if (bitn_q > TA_LAST)  rdata_d = {rdata_q[DATA_W-2:0], mdio_i};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      read_q   <= 1'b0;
      sreg_q   <= '1;
      bitn_q   <= '0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      read_q   <= read_d;
      sreg_q   <= sreg_d;
      bitn_q   <= bitn_d;
      rdata_q  <= rdata_d;
      err_q    <= err_d;
    end
  end

  // R9: driven level moves only on a falling clock tick
  p_out_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q) && !$stable(mdio_o)) |-> $past(fall_tick));
  // R7: the error flag can only rise during a read frame
  p_err_only_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> read_q);
endmodule

// File: rtl/mdio45_master.sv
module mdio45_master
  import mdio45_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int STAT_PAD = 32 - 8 - DIV_W;

  logic [DIV_W-1:0]   div_q;
  logic [PHYAD_W-1:0] port_q, dev_q;
  logic [DATA_W-1:0]  addr_q, data_q;
  mdio_op_e           kind_q;

  logic               busy, done, rd_err;
  logic               rise_tick, fall_tick;
  logic [DATA_W-1:0]  shift_rdata;
  logic               wr_ok, wr_stat, wr_ctrl, wr_addr, wr_data;
  logic               start, start_rd;
  mdio_op_e           op;
  logic [PHYAD_W-1:0] f_port, f_dev;
  logic [DATA_W-1:0]  f_pay;
  logic [1:0]         f_ta;
  logic [FRAME_W-1:0] frame;
  logic               data_busy;
  logic               unused_wdata;

  assign wr_ok    = bus_wr && !busy;
  assign wr_stat  = wr_ok && (bus_addr == REG_STAT);
  assign wr_ctrl  = wr_ok && (bus_addr == REG_CTRL);
  assign wr_addr  = wr_ok && (bus_addr == REG_ADDR);
  assign wr_data  = wr_ok && (bus_addr == REG_DATA);
  assign start_rd = wr_ctrl && bus_wdata[CTRL_RD_BIT];
  assign start    = wr_addr || wr_data || start_rd;
  assign unused_wdata = ^{bus_wdata[31:16], bus_wdata[14:13], bus_wdata[7:5]};

  always_comb begin
    op     = OP_ADDR;
    f_port = port_q;
    f_dev  = dev_q;
    f_pay  = bus_wdata[DATA_W-1:0];
    f_ta   = 2'b10;
    if (start_rd) begin
      op     = OP_READ;
      f_port = bus_wdata[12:8];
      f_dev  = bus_wdata[4:0];
      f_pay  = '1;
      f_ta   = 2'b11;
    end else if (wr_data) begin
      op = OP_WRITE;
    end
  end

  assign frame = {{PRE_W{1'b1}}, 2'b00, op, f_port, f_dev, f_ta, f_pay};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(DIV_RST);
      port_q <= '0;
      dev_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      kind_q <= OP_ADDR;
    end else begin
      if (wr_stat) div_q <= bus_wdata[8 +: DIV_W];
      if (wr_ctrl) begin
        port_q <= bus_wdata[12:8];
        dev_q  <= bus_wdata[4:0];
      end
      if (wr_addr) addr_q <= bus_wdata[DATA_W-1:0];
      if (wr_data) data_q <= bus_wdata[DATA_W-1:0];
      else if (done && (kind_q == OP_READ)) data_q <= shift_rdata;
      if (start) kind_q <= op;
    end
  end

  assign data_busy = busy && (kind_q != OP_ADDR);

  always_comb begin
    unique case (bus_addr)
      REG_STAT: bus_rdata = {{STAT_PAD{1'b0}}, div_q, 6'b0, rd_err, busy};
      REG_CTRL: bus_rdata = {16'b0, 3'b0, port_q, 3'b0, dev_q};
      REG_ADDR: bus_rdata = {16'b0, addr_q};
      default:  bus_rdata = {data_busy, 15'b0, data_q};
    endcase
  end

  mdio45_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .div       (div_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio45_shifter u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_read (start_rd),
    .frame      (frame),
    .rise_tick  (rise_tick),
    .fall_tick  (fall_tick),
    .mdio_i     (mdio_i),
    .active     (busy),
    .done       (done),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .rdata      (shift_rdata),
    .rd_err     (rd_err)
  );

  // R8: writes during a frame leave the configuration untouched
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && busy) |=> ($stable(addr_q) && $stable(port_q) && $stable(dev_q) && $stable(div_q)));
  // R9: busy clears together with the last falling clock edge
  p_busy_fall_mdc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(mdc));
  // R3: an accepted frame start drives the preamble at once
  p_start_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && mdio_oe && mdio_o && !mdc));
  // R7: a new read clears the error flag
  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd |=> !rd_err);
endmodule

// File: tb/mdio45_master_bench.sv
`timescale 1ns/1ps
module mdio45_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  mdio45_master u_mdio45_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // reference model state
  int         m_div = 100;
  logic [4:0] m_port = 0, m_dev = 0, m_fport = 0, m_fdev = 0;
  logic [15:0] m_addr = 0, m_data = 0, m_fpay = 0;
  logic [1:0] m_fop = 0;
  int         m_kind = 0;   // 0 address, 1 write, 2 read
  bit         m_err = 0, m_active = 0;
  int         m_k = 0;
  bit         phy_here = 1;
  logic [15:0] phy_resp = 16'h0;

  function automatic logic bit_at(int b);
    if (b < 32) return 1'b1;
    if (b < 34) return 1'b0;
    if (b < 36) return m_fop[1 - (b - 34)];
    if (b < 41) return m_fport[4 - (b - 36)];
    if (b < 46) return m_fdev[4 - (b - 41)];
    if (b == 46) return 1'b1;
    if (b == 47) return 1'b0;
    return m_fpay[15 - (b - 48)];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 100; m_port = 0; m_dev = 0; m_addr = 0; m_data = 0;
      m_err = 0; m_active = 0; m_k = 0; m_kind = 0;
    end else begin
      bit was_busy;
      int half;
      was_busy = m_active;
      half = m_div + 1;
      if (m_active) begin
        m_k++;
        if (m_kind == 2 && m_k == 95 * half && !phy_here) m_err = 1;
        if (m_k == 128 * half) begin
          m_active = 0;
          if (m_kind == 2) m_data = phy_here ? phy_resp : 16'hFFFF;
        end
      end
      if (bus_wr && !was_busy) begin
        case (bus_addr)
          2'd0: m_div = int'(bus_wdata[15:8]);
          2'd1: begin
            m_port = bus_wdata[12:8]; m_dev = bus_wdata[4:0];
            if (bus_wdata[15]) begin
              m_active = 1; m_k = 0; m_kind = 2; m_err = 0;
              m_fop = 2'b11; m_fport = m_port; m_fdev = m_dev; m_fpay = 16'hFFFF;
            end
          end
          2'd2: begin
            m_addr = bus_wdata[15:0];
            m_active = 1; m_k = 0; m_kind = 0;
            m_fop = 2'b00; m_fport = m_port; m_fdev = m_dev; m_fpay = m_addr;
          end
          default: begin
            m_data = bus_wdata[15:0];
            m_active = 1; m_k = 0; m_kind = 1;
            m_fop = 2'b01; m_fport = m_port; m_fdev = m_dev; m_fpay = m_data;
          end
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the clock edge
  always @(negedge clk) begin
    #1;
    begin
      int half, b;
      logic e_mdc, e_oe, phy_bit;
      logic [31:0] e_rd;
      half  = m_div + 1;
      b     = m_k / (2 * half);
      e_mdc = m_active && (((m_k / half) % 2) == 1);
      e_oe  = m_active && !(m_kind == 2 && b >= 46);
      if (!rst_n) begin
        chk("R1 mdc", {31'b0, mdc}, 32'd0);
        chk("R1 oe", {31'b0, mdio_oe}, 32'd0);
      end
      chk("R2 mdc", {31'b0, mdc}, {31'b0, e_mdc});
      chk("R5 oe", {31'b0, mdio_oe}, {31'b0, e_oe});
      if (e_oe)
        chk(m_kind == 0 ? "R3 R9 mdio" : m_kind == 1 ? "R4 R9 mdio" : "R5 R9 mdio",
            {31'b0, mdio_o}, {31'b0, bit_at(b)});
      case (bus_addr)
        2'd0: e_rd = (32'(m_div) << 8) | (32'(m_err) << 1) | 32'(m_active);
        2'd1: e_rd = {19'b0, m_port, 3'b0, m_dev};
        2'd2: e_rd = {16'b0, m_addr};
        default: e_rd = {(m_active && m_kind != 0), 15'b0, m_data};
      endcase
      chk(bus_addr == 2'd0 ? "R7 R1 stat" : bus_addr == 2'd1 ? "R8 ctrl" :
          bus_addr == 2'd2 ? "R8 addr" : "R6 R4 data", bus_rdata, e_rd);
      phy_bit = 1'b1;
      if (m_active && m_kind == 2 && phy_here && b >= 47)
        phy_bit = (b == 47) ? 1'b0 : phy_resp[15 - (b - 48)];
      mdio_i = e_oe ? bit_at(b) : phy_bit;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_addr = bus_addr + 2'd1;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_active) idle(1);
    idle(2);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R2 small divider, R3 address frame
    wr(2'd0, 32'h0000_0200);
    wr(2'd1, 32'h0000_1503);
    wr(2'd2, 32'h0000_A5C3);
    idle(40);
    // R8 writes during a frame are dropped
    wr(2'd1, 32'h0000_9F1F);
    wr(2'd2, 32'h0000_1234);
    wr(2'd0, 32'h0000_0700);
    wait_idle();
    // R4 write frame
    wr(2'd3, 32'hFFFF_5A0F);
    wait_idle();
    // R5 R6 read with responder, fastest clock
    wr(2'd0, 32'h0000_0000);
    phy_here = 1; phy_resp = 16'hBEEF;
    wr(2'd1, 32'h0000_8201);
    wait_idle();
    // R7 no responder
    phy_here = 0;
    wr(2'd1, 32'h0000_8A0C);
    wait_idle();
    // R7 clear on next read, R6 new data
    wr(2'd0, 32'h0000_0300);
    phy_here = 1; phy_resp = 16'h1357;
    wr(2'd1, 32'h0000_9F1F);
    wait_idle();
    // R8 write on the completion edge is dropped, next cycle accepted
    wr(2'd0, 32'h0000_0100);
    wr(2'd2, 32'h0000_00F0);
    while (!(m_active && m_k == 128 * (m_div + 1) - 1)) idle(1);
    wr(2'd2, 32'h0000_7777);
    wr(2'd2, 32'h0000_2222);
    wait_idle();
    // R2 default-sized divider
    wr(2'd0, 32'h0000_6400);
    wr(2'd3, 32'h0000_C3A5);
    wait_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule